// File: doc/BRIEF.md
# ADC Step Sequencer with Averaging

The block controls a successive-approximation converter through a fixed set of sixteen programmable conversion steps. Each step picks one of eight analog inputs and carries its own settling (open) delay, its own start-of-conversion hold width and its own averaging setting. For every enabled step the sequencer waits out the settling time and then holds start-of-conversion for the sample window. It collects as many conversions as the averaging setting requests, sums them in a guarded accumulator and divides by a right shift. The averaged value goes out on a valid/ready stream, tagged with the step index and a coordinate kind.

In touchscreen mode a charge phase of programmable length opens each pass, and the pen-detect input is sampled in the cycle after it. With N coordinate reads the first 2N+2 steps are touch steps: N for X, then N for Y, then two for pressure (Z). The steps above them serve general channels. When no pen is present, the touch steps are skipped for that pass. A pass starts from an enable pulse. A continuous-mode input chains passes back to back.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is idle: busy_o, adc_soc_o, charge_o and res_valid_o are low, and every step is disabled, so a pass started with no configuration writes ends without producing a result.
- R2: A configuration write stores cfg_wdata_i into step cfg_addr_i with layout bit 32 enable, bits 31:29 averaging code, bits 28:26 channel, bits 25:18 sample width, bits 17:0 open delay; a pass visits the enabled steps in ascending index order and skips disabled ones.
- R3: With touch mode off, the first rise of adc_soc_o in a pass comes open-delay + 2 cycles after the clock edge that samples en_i high (one cycle of step search, one of step load, then the open delay).
- R4: adc_soc_o stays high for exactly max(sample width, 1) cycles for every conversion of a step.
- R5: Averaging code c takes 2^min(c,4) conversions (codes 0 and 1 give one and two, codes above 4 give sixteen); the result is their sum right-shifted by min(c,4) with the fraction dropped, and sixteen full-scale samples do not overflow.
- R6: While res_valid_o is high and res_ready_i is low, the result, its tag and valid stay unchanged and no new conversion starts; nothing is lost.
- R7: res_step_o carries the step index; res_kind_o is 0 for X, 1 for Y, 2 for Z and 3 for a general channel, and is 3 for every step when touch mode is off.
- R8: In touch mode charge_o is high for max(charge delay, 1) cycles at the start of each pass; with pen_down_i high in the following cycle all enabled steps run, with pen_down_i low the pass resumes at step 2N+2.
- R9: With cont_i high at the end of a pass a new pass starts from step 0; with it low the block returns to idle and busy_o falls.
- R10: A configuration write to the step in progress does not change that step's channel, sample width or sample count; it takes effect at the step's next visit.
- R11: adc_chan_o holds the active step's channel for the whole time adc_soc_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Starts a pass when the block is idle |
| cont_i | input | 1 | Chain another pass after the last enabled step |
| ts_en_i | input | 1 | Touchscreen mode enable |
| ts_reads_i | input | 3 | Coordinate reads N per axis |
| charge_dly_i | input | 18 | Charge phase length in cycles |
| pen_down_i | input | 1 | Pen-detect level, sampled after charge |
| cfg_we_i | input | 1 | Step configuration write strobe |
| cfg_addr_i | input | 4 | Step index to write |
| cfg_wdata_i | input | 33 | Step configuration word |
| adc_chan_o | output | 3 | Selected analog input |
| adc_soc_o | output | 1 | Start of conversion / sample window |
| adc_done_i | input | 1 | Conversion finished, data valid |
| adc_data_i | input | 12 | Conversion result |
| charge_o | output | 1 | Touch panel charge phase |
| res_valid_o | output | 1 | Averaged result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 12 | Averaged result |
| res_step_o | output | 4 | Step index of the result |
| res_kind_o | output | 2 | Coordinate kind of the result |
| busy_o | output | 1 | A pass is in progress |

## Verification
Two events can land on the same cycle: a configuration write aimed at the step that is converting, and that step's own sample-window and averaging sequence; the bench writes step 0 while its first start-of-conversion pulse is high and judges by counting pulses and watching the channel, which must follow the old setting until the next pass. The second overlap is the end of a pass meeting both the continuous-mode decision and a stalled output: the bench holds ready low on the second pass's result, clears continuous mode during the stall, then releases, and expects exactly two conversions and a return to idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NSTEP   = 16;
  localparam int STEP_W  = $clog2(NSTEP);
  localparam int DATA_W  = 12;
  localparam int GUARD_W = 4;
  localparam int ACC_W   = DATA_W + GUARD_W;
  localparam int ODLY_W  = 18;
  localparam int SDLY_W  = 8;
  localparam int CH_W    = 3;
  localparam int AVG_W   = 3;
  localparam int MAX_LOG = GUARD_W;
  localparam int SMP_W   = MAX_LOG + 1;
  localparam int RD_W    = 3;
  localparam int CFG_W   = 1 + AVG_W + CH_W + SDLY_W + ODLY_W;

  typedef struct packed {
    logic              en;
    logic [AVG_W-1:0]  avg;
    logic [CH_W-1:0]   chan;
    logic [SDLY_W-1:0] sdly;
    logic [ODLY_W-1:0] odly;
  } step_cfg_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHARGE, ST_PEN, ST_NEXT, ST_SEL,
    ST_OPEN, ST_SAMPLE, ST_CONV, ST_OUT
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_X = 2'd0, KIND_Y = 2'd1, KIND_Z = 2'd2, KIND_ADC = 2'd3
  } kind_e;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int N = NSTEP,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  step_cfg_t     wdata_i,
  input  logic [AW-1:0] rd_idx_i,
  output step_cfg_t     rd_o,
  output logic [N-1:0]  en_o
);
  logic [N*CFG_W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_ent
    step_cfg_t r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           r_q <= '0;
      else if (we_i && addr_i == AW'(g))     r_q <= wdata_i;
    end
    assign flat[g*CFG_W +: CFG_W] = r_q;
    assign en_o[g] = r_q.en;
  end

  assign rd_o = step_cfg_t'(flat[rd_idx_i*CFG_W +: CFG_W]);
endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
  parameter int DW = 12,
  parameter int GW = 4,
  parameter int LW = 3,
  localparam int AW = DW + GW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] log_i,
  output logic [DW-1:0] avg_o
);
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= acc_q + AW'(data_i);
  end

  assign avg_o = DW'(acc_q >> log_i);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic              ts_en_i,
  input  logic [RD_W-1:0]   ts_reads_i,
  input  logic [ODLY_W-1:0] charge_dly_i,
  input  logic              pen_down_i,
  input  logic [NSTEP-1:0]  en_vec_i,
  input  step_cfg_t         cfg_i,
  output logic [STEP_W-1:0] idx_o,
  input  logic              adc_done_i,
  output logic              soc_o,
  output logic              charge_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              acc_clr_o,
  output logic              acc_add_o,
  output logic [AVG_W-1:0]  log_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [1:0]        kind_o,
  output logic              busy_o
);
  seq_state_e        st_q;
  logic [STEP_W-1:0] idx_q;
  logic [STEP_W:0]   nxt_q;
  logic [ODLY_W-1:0] cnt_q;
  logic [SDLY_W-1:0] sdly_q;
  logic [CH_W-1:0]   chan_q;
  logic [AVG_W-1:0]  log_q;
  logic [SMP_W-1:0]  smp_q;
  logic              found;
  logic [STEP_W-1:0] fidx;
  logic [STEP_W:0]   n_ext, ts_span, idx_ext;
  logic [AVG_W-1:0]  cfg_log;
  logic              last_smp;

  // lowest enabled step at or above the search start
  always_comb begin
    found = 1'b0;
    fidx  = '0;
    for (int j = NSTEP - 1; j >= 0; j--) begin
      if (en_vec_i[j] && ((STEP_W+1)'(j) >= nxt_q)) begin
        found = 1'b1;
        fidx  = STEP_W'(j);
      end
    end
  end

  assign n_ext    = (STEP_W+1)'(ts_reads_i);
  assign ts_span  = (n_ext << 1) + (STEP_W+1)'(2);
  assign idx_ext  = {1'b0, idx_q};
  assign cfg_log  = (cfg_i.avg > AVG_W'(MAX_LOG)) ? AVG_W'(MAX_LOG) : cfg_i.avg;
  assign last_smp = (smp_q == ((SMP_W'(1) << log_q) - SMP_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      nxt_q  <= '0;
      cnt_q  <= '0;
      sdly_q <= '0;
      chan_q <= '0;
      log_q  <= '0;
      smp_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en_i) begin
          nxt_q <= '0;
          if (ts_en_i) begin cnt_q <= charge_dly_i; st_q <= ST_CHARGE; end
          else st_q <= ST_NEXT;
        end
        ST_CHARGE: if (cnt_q <= ODLY_W'(1)) st_q <= ST_PEN;
                   else cnt_q <= cnt_q - ODLY_W'(1);
        ST_PEN: begin
          nxt_q <= pen_down_i ? '0 : ts_span;
          st_q  <= ST_NEXT;
        end
        ST_NEXT: if (found) begin
          idx_q <= fidx;
          st_q  <= ST_SEL;
        end else if (cont_i) begin
          nxt_q <= '0;
          if (ts_en_i) begin cnt_q <= charge_dly_i; st_q <= ST_CHARGE; end
        end else st_q <= ST_IDLE;
        ST_SEL: begin
          chan_q <= cfg_i.chan;
          sdly_q <= cfg_i.sdly;
          log_q  <= cfg_log;
          smp_q  <= '0;
          if (cfg_i.odly == '0) begin
            cnt_q <= ODLY_W'(cfg_i.sdly);
            st_q  <= ST_SAMPLE;
          end else begin
            cnt_q <= cfg_i.odly;
            st_q  <= ST_OPEN;
          end
        end
        ST_OPEN: if (cnt_q <= ODLY_W'(1)) begin
          cnt_q <= ODLY_W'(sdly_q);
          st_q  <= ST_SAMPLE;
        end else cnt_q <= cnt_q - ODLY_W'(1);
        ST_SAMPLE: if (cnt_q <= ODLY_W'(1)) st_q <= ST_CONV;
                   else cnt_q <= cnt_q - ODLY_W'(1);
        ST_CONV: if (adc_done_i) begin
          if (last_smp) st_q <= ST_OUT;
          else begin
            smp_q <= smp_q + SMP_W'(1);
            cnt_q <= ODLY_W'(sdly_q);
            st_q  <= ST_SAMPLE;
          end
        end
        ST_OUT: if (res_ready_i) begin
          nxt_q <= idx_ext + (STEP_W+1)'(1);
          st_q  <= ST_NEXT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!ts_en_i || idx_ext >= ts_span) kind_o = KIND_ADC;
    else if (idx_ext < n_ext)           kind_o = KIND_X;
    else if (idx_ext < (n_ext << 1))    kind_o = KIND_Y;
    else                                kind_o = KIND_Z;
  end

  assign idx_o       = idx_q;
  assign soc_o       = (st_q == ST_SAMPLE);
  assign charge_o    = (st_q == ST_CHARGE);
  assign chan_o      = chan_q;
  assign acc_clr_o   = (st_q == ST_SEL);
  assign acc_add_o   = (st_q == ST_CONV) && adc_done_i;
  assign log_o       = log_q;
  assign res_valid_o = (st_q == ST_OUT);
  assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic              ts_en_i,
  input  logic [RD_W-1:0]   ts_reads_i,
  input  logic [ODLY_W-1:0] charge_dly_i,
  input  logic              pen_down_i,
  input  logic              cfg_we_i,
  input  logic [STEP_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CH_W-1:0]   adc_chan_o,
  output logic              adc_soc_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              charge_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [STEP_W-1:0] res_step_o,
  output logic [1:0]        res_kind_o,
  output logic              busy_o
);
  step_cfg_t         cur_cfg;
  logic [NSTEP-1:0]  en_vec;
  logic [STEP_W-1:0] idx;
  logic              acc_clr, acc_add;
  logic [AVG_W-1:0]  log_sh;

  adc_seq_cfg #(.N(NSTEP)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (step_cfg_t'(cfg_wdata_i)),
    .rd_idx_i (idx),
    .rd_o     (cur_cfg),
    .en_o     (en_vec)
  );

  adc_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .en_i, .cont_i, .ts_en_i, .ts_reads_i,
    .charge_dly_i, .pen_down_i,
    .en_vec_i    (en_vec),
    .cfg_i       (cur_cfg),
    .idx_o       (idx),
    .adc_done_i,
    .soc_o       (adc_soc_o),
    .charge_o,
    .chan_o      (adc_chan_o),
    .acc_clr_o   (acc_clr),
    .acc_add_o   (acc_add),
    .log_o       (log_sh),
    .res_valid_o,
    .res_ready_i,
    .kind_o      (res_kind_o),
    .busy_o
  );

  adc_seq_avg #(.DW(DATA_W), .GW(GUARD_W), .LW(AVG_W)) u_avg (
    .clk_i, .rst_ni,
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .data_i (adc_data_i),
    .log_i  (log_sh),
    .avg_o  (res_data_o)
  );

  assign res_step_o = idx;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              adc_soc_o,
  input logic              charge_o,
  input logic [CH_W-1:0]   adc_chan_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [DATA_W-1:0] res_data_o,
  input logic [STEP_W-1:0] res_step_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!adc_soc_o && !charge_o && !res_valid_o)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_step_o))); // R6
  AST_NO_SOC_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !adc_soc_o); // R6
  AST_CHARGE_SOC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(charge_o && adc_soc_o)); // R8
  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_soc_o && $past(adc_soc_o)) |-> $stable(adc_chan_o)); // R11
endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .adc_soc_o   (adc_soc_o),
  .charge_o    (charge_o),
  .adc_chan_o  (adc_chan_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o),
  .res_step_o  (res_step_o)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  import adc_seq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, cont = 1'b0, ts_en = 1'b0, pen = 1'b0;
  logic [2:0] ts_reads = '0;
  logic [17:0] charge_dly = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [32:0] cfg_wdata = '0;
  logic [2:0] adc_chan;
  logic soc, adc_done = 1'b0, charge, res_valid, res_ready = 1'b1, busy;
  logic [11:0] adc_data = '0, res_data;
  logic [3:0] res_step;
  logic [1:0] res_kind;

  adc_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cont_i(cont), .ts_en_i(ts_en),
    .ts_reads_i(ts_reads), .charge_dly_i(charge_dly), .pen_down_i(pen),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .adc_chan_o(adc_chan), .adc_soc_o(soc), .adc_done_i(adc_done),
    .adc_data_i(adc_data), .charge_o(charge), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .res_data_o(res_data), .res_step_o(res_step),
    .res_kind_o(res_kind), .busy_o(busy)
  );

  int errors = 0, checks = 0;
  int adc_base = 0, adc_inc = 0, k_org = 0, exp_w = 0, exp_chan = -1;
  int adc_k = 0, dly = 0, pulses = 0, wbad = 0, cbad = 0, w_cur = 0, ch_cur = 0, ch_last = 0;
  logic prev_soc = 1'b0;

  // converter model: done two cycles after the sample window closes
  always @(negedge clk) begin
    if (adc_done) adc_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        adc_done = 1'b1;
        adc_data = 12'(adc_base + adc_inc * (adc_k - k_org));
        adc_k++;
      end
    end
    if (prev_soc && !soc) dly = 2;
    prev_soc = soc;
  end

  // pulse monitor
  always @(negedge clk) begin
    if (soc) begin
      w_cur++;
      if (exp_chan >= 0 && int'(adc_chan) != exp_chan) cbad++;
    end else if (w_cur > 0) begin
      pulses++;
      if (exp_w != 0 && w_cur != exp_w) wbad++;
      w_cur = 0;
    end
    if (charge) ch_cur++;
    else if (ch_cur > 0) begin ch_last = ch_cur; ch_cur = 0; end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [32:0] mk(bit e, int av, int ch, int sd, int od);
    return {e, 3'(av), 3'(ch), 8'(sd), 18'(od)};
  endfunction

  task automatic wr(int a, logic [32:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clr_all();
    for (int i = 0; i < NSTEP; i++) wr(i, '0);
  endtask

  task automatic start();
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic get_res(output int d, output int s, output int k, output bit ok);
    ok = 0; d = 0; s = 0; k = 0; res_ready = 1'b1;
    for (int i = 0; i < 30000 && !ok; i++) begin
      @(negedge clk);
      if (res_valid) begin ok = 1; d = res_data; s = res_step; k = res_kind; end
    end
    if (ok) @(negedge clk);
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 30000 && !ok; i++) begin
      @(negedge clk);
      if (res_valid) ok = 1;
    end
  endtask

  typedef struct packed {
    logic [17:0] od; logic [7:0] sd; logic [2:0] av;
    logic [11:0] base; logic [11:0] inc; logic [3:0] st; logic [2:0] ch;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{18'd0,  8'd1,   3'd0, 12'd100,  12'd0, 4'd0,  3'd1},
    '{18'd7,  8'd3,   3'd1, 12'd1000, 12'd3, 4'd3,  3'd5},
    '{18'd1,  8'd0,   3'd2, 12'd4092, 12'd1, 4'd15, 3'd7},
    '{18'd20, 8'd5,   3'd3, 12'd10,   12'd5, 4'd8,  3'd2},
    '{18'd2,  8'd2,   3'd7, 12'd4095, 12'd0, 4'd6,  3'd0},
    '{18'd3,  8'd255, 3'd4, 12'd0,    12'd1, 4'd11, 3'd4}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d, s, k, lat, n, lg, sum, p0, wb0, cb0;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {soc, charge, res_valid}, 0);
    start();
    @(negedge clk); @(negedge clk);
    chk("R1 empty pass ends", busy, 0);
    chk("R1 no result", res_valid, 0);

    // table walk: single step, timing and averaging
    foreach (VEC[i]) begin
      clr_all();
      wr(VEC[i].st, mk(1, VEC[i].av, VEC[i].ch, VEC[i].sd, VEC[i].od));
      lg = (VEC[i].av > 4) ? 4 : int'(VEC[i].av);
      n = 1 << lg;
      sum = 0;
      for (int j = 0; j < n; j++) sum += int'(VEC[i].base) + int'(VEC[i].inc) * j;
      exp_w = (VEC[i].sd == 0) ? 1 : int'(VEC[i].sd);
      exp_chan = VEC[i].ch;
      adc_base = VEC[i].base; adc_inc = VEC[i].inc; k_org = adc_k;
      p0 = pulses; wb0 = wbad; cb0 = cbad;
      start();
      lat = 0;
      while (!soc && lat < 1000) begin @(negedge clk); lat++; end
      chk("R3 open delay latency", lat, int'(VEC[i].od) + 2);
      get_res(d, s, k, ok);
      chk("R5 result arrives", ok, 1);
      chk("R5 sample count", pulses - p0, n);
      chk("R5 averaged value", d, sum >> lg);
      chk("R4 sample width", wbad - wb0, 0);
      chk("R11 channel during sample", cbad - cb0, 0);
      chk("R7 step tag", s, int'(VEC[i].st));
      chk("R7 kind general", k, 3);
    end
    exp_w = 0; exp_chan = -1;

    // R2: ascending order, disabled steps skipped
    clr_all();
    wr(9, mk(1, 0, 3, 1, 1));
    wr(2, mk(1, 0, 4, 1, 0));
    wr(5, mk(1, 0, 6, 2, 4));
    wr(6, mk(0, 0, 1, 1, 0));
    adc_base = 50; adc_inc = 10; k_org = adc_k;
    start();
    get_res(d, s, k, ok); chk("R2 first step", s, 2); chk("R2 first data", d, 50);
    get_res(d, s, k, ok); chk("R2 second step", s, 5); chk("R2 second data", d, 60);
    get_res(d, s, k, ok); chk("R2 third step", s, 9); chk("R2 third data", d, 70);
    @(negedge clk); @(negedge clk);
    chk("R9 idle after pass", busy, 0);

    // R6: backpressure
    clr_all();
    wr(4, mk(1, 0, 2, 1, 0));
    adc_base = 777; adc_inc = 0; k_org = adc_k; p0 = pulses;
    res_ready = 1'b0;
    start();
    wait_valid(ok);
    chk("R6 valid reached", ok, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6 held under stall", {res_valid, res_data, res_step}, {1'b1, 12'd777, 4'd4});
    end
    chk("R6 no extra sampling", pulses - p0, 1);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R6 released", res_valid, 0);

    // R8: touch mode, pen down then pen up
    clr_all();
    for (int i = 0; i < 5; i++) wr(i, mk(1, 0, i, 1, 0));
    ts_en = 1'b1; ts_reads = 3'd1; charge_dly = 18'd5; pen = 1'b1;
    adc_base = 0; adc_inc = 1; k_org = adc_k;
    start();
    for (int i = 0; i < 5; i++) begin
      get_res(d, s, k, ok);
      chk("R8 touch step order", s, i);
      chk("R7 touch kind", k, (i < 1) ? 0 : (i < 2) ? 1 : (i < 4) ? 2 : 3);
    end
    chk("R8 charge width", ch_last, 5);
    charge_dly = 18'd0; pen = 1'b0;
    start();
    get_res(d, s, k, ok);
    chk("R8 pen up skips touch steps", s, 4);
    chk("R8 zero charge is one cycle", ch_last, 1);
    @(negedge clk); @(negedge clk);
    chk("R8 pass ends", busy, 0);
    ts_en = 1'b0;

    // R9: continuous mode, cleared during a stall
    clr_all();
    wr(7, mk(1, 0, 3, 1, 2));
    p0 = pulses; cont = 1'b1;
    start();
    get_res(d, s, k, ok);
    res_ready = 1'b0;
    wait_valid(ok);
    chk("R9 second pass result", ok, 1);
    chk("R9 restart step", res_step, 7);
    cont = 1'b0; res_ready = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 back to idle", busy, 0);
    chk("R9 exactly two conversions", pulses - p0, 2);

    // R10: write to the active step
    clr_all();
    wr(0, mk(1, 2, 1, 4, 3));
    adc_base = 200; adc_inc = 4; k_org = adc_k;
    p0 = pulses; cb0 = cbad; exp_chan = 1;
    start();
    while (!soc) @(negedge clk);
    wr(0, mk(1, 0, 6, 1, 0));
    get_res(d, s, k, ok);
    chk("R10 old sample count kept", pulses - p0, 4);
    chk("R10 old average kept", d, 206);
    chk("R10 old channel kept", cbad - cb0, 0);
    exp_chan = 6; p0 = pulses; cb0 = cbad;
    start();
    get_res(d, s, k, ok);
    chk("R10 new setting next visit", pulses - p0, 1);
    chk("R11 new channel", cbad - cb0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule